// File: doc/BRIEF.md
# Width-Configurable Masked Vector ALU

This block executes one integer ALU operation over the elements of a vector register file. Each of the 32 vector registers is 32 words of 64 bits. A run-time width setting splits every word into four 16-bit, two 32-bit or one 64-bit element, so a register holds 128, 64 or 32 elements. A separate file of 32 flag registers keeps one bit per element. Flag registers serve two purposes. One selected register can gate each element's write-back. A second selected register receives a per-element status bit: signed overflow for add and subtract, and saturation for saturating add.

A command carries an opcode, a destination, two sources, an operand form and flag-register selects. The block accepts it while idle and then processes one 64-bit word per clock. It pulses a done strobe once the last word is written. The vector-scalar and scalar-vector forms replicate a 64-bit scalar's low element across every element position. The width and length settings are sampled when a command is accepted. A word-wide load port and a combinational read port on each file give the neighbouring memory pipeline access to the registers between operations.

Top module: `vxu_top`

## Requirements
- R1: While reset is asserted, and after it is released, `busy` and `done` are 0.
- R2: `cfg_width` 0 selects 16-bit elements (4 per word, 128 per register), 1 selects 32-bit (2 per word, 64 per register), and 2 selects 64-bit (1 per word, 32 per register). Code 3 behaves as 2. Element e sits in word e/(elements per word), at bit offset (e mod elements per word) times the width.
- R3: `cfg_len` gives the number of elements processed, counted from element 0. A value above the capacity at the selected width is clamped to that capacity. Elements at or beyond the effective length keep their data and their status bit.
- R4: Opcode 0 is add, 1 is subtract (first operand minus second), 2 is AND, 3 is OR and 4 is XOR. Add and subtract wrap modulo 2 to the power of the element width.
- R5: Opcode 5 is saturating signed add. A result outside the signed range of the element width is clamped to the nearest limit, and the element's status bit is set to 1. A result inside the range sets the bit to 0.
- R6: With `cmd_masked`=1, an element whose bit in flag register `cmd_mreg` is 0 keeps both its data and its status bit. With `cmd_masked`=0, every element below the effective length is written.
- R7: `cmd_form` 0 takes both operands from registers `cmd_vs1` and `cmd_vs2`. Form 1 replaces the second operand with the scalar's low element. Form 2 replaces the first operand with it.
- R8: A command accepted at a clock edge with N active words (N = ceiling of effective length over elements per word) brings `done` high for exactly one cycle, after N further edges. With N=0 it is high right after the accepting edge and no register changes. `busy` is high during the N word cycles.
- R9: `cmd_valid`, `ld_we` and `fl_we` have no effect while `busy` is high.
- R10: For each written element, add and subtract store the signed-overflow bit into flag register `cmd_freg` at the element's index. Logic operations store 0 there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, accepted when not busy |
| cmd_op | input | 3 | Opcode |
| cmd_form | input | 2 | Operand form |
| cmd_vd | input | 5 | Destination vector register |
| cmd_vs1 | input | 5 | First source vector register |
| cmd_vs2 | input | 5 | Second source vector register |
| cmd_masked | input | 1 | Enable write gating by a flag register |
| cmd_mreg | input | 5 | Flag register used as write mask |
| cmd_freg | input | 5 | Flag register receiving status bits |
| cmd_scalar | input | 64 | Scalar operand, low element broadcast |
| cfg_width | input | 2 | Element width setting |
| cfg_len | input | 8 | Requested element count |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| ld_we | input | 1 | Vector word load enable |
| ld_reg | input | 5 | Vector register to load |
| ld_word | input | 5 | Word index to load |
| ld_data | input | 64 | Load data |
| fl_we | input | 1 | Flag register load enable |
| fl_reg | input | 5 | Flag register to load |
| fl_data | input | 128 | Flag load data |
| rd_reg | input | 5 | Vector register to read |
| rd_word | input | 5 | Word index to read |
| rd_data | output | 64 | Read data |
| fr_reg | input | 5 | Flag register to read |
| fr_data | output | 128 | Flag read data |

## Verification
In a single word cycle the block both reads a mask bit and writes a status bit. When `cmd_mreg` equals `cmd_freg`, the two land on the same flag register, and the destination word may be a source word at the same moment. The bench provokes this with a masked saturating add in place (destination equal to first source, mask register equal to status register) at full 16-bit length. It judges the result against an element-by-element model in which every element reads its own old mask bit. The bench also drives a second command and two loads in a busy cycle, and checks that the target registers stay unchanged and that no extra operation follows.

// File: rtl/vxu_pkg.sv
package vxu_pkg;
  localparam int WORD_W = 64;
  localparam int SLOTS  = 4;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_SADD = 3'd5
  } vop_e;

  typedef enum logic [1:0] {
    FM_VV = 2'd0,
    FM_VS = 2'd1,
    FM_SV = 2'd2
  } vform_e;

  // width code 3 is folded onto the 64-bit setting
  function automatic logic [1:0] norm_width(logic [1:0] w);
    return (w == 2'd3) ? 2'd2 : w;
  endfunction

  // replicate the low element of a scalar over a whole word
  function automatic logic [63:0] splat(logic [63:0] s, logic [1:0] wsel);
    case (wsel)
      2'd0:    return {4{s[15:0]}};
      2'd1:    return {2{s[31:0]}};
      default: return s;
    endcase
  endfunction

  // operands arrive left-aligned (element MSB at bit 63, zeros below),
  // so one 64-bit adder and one sign test serve every element width
  function automatic logic [64:0] aligned_op(logic [2:0] op, logic [63:0] x, logic [63:0] y);
    logic [63:0] s, d, lim, r;
    logic        f, ov;
    s   = x + y;
    d   = x - y;
    lim = x[63] ? {1'b1, 63'd0} : {1'b0, {63{1'b1}}};
    ov  = (x[63] == y[63]) && (s[63] != x[63]);
    r   = x;
    f   = 1'b0;
    case (vop_e'(op))
      OP_ADD:  begin r = s; f = ov; end
      OP_SUB:  begin r = d; f = (x[63] != y[63]) && (d[63] != x[63]); end
      OP_AND:  r = x & y;
      OP_OR:   r = x | y;
      OP_XOR:  r = x ^ y;
      OP_SADD: begin r = ov ? lim : s; f = ov; end
      default: r = x;
    endcase
    return {f, r};
  endfunction
endpackage

// File: rtl/vxu_word_alu.sv
module vxu_word_alu
  import vxu_pkg::*;
(
  input  logic [2:0]        op,
  input  logic [1:0]        wsel,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] res,
  output logic [SLOTS-1:0]  flg
);
  logic [WORD_W-1:0] part [SLOTS];

  genvar j;
  generate
    for (j = 0; j < SLOTS; j++) begin : g_slot
      logic [7:0]        elw;
      logic [7:0]        lo;
      logic [7:0]        up;
      logic              live;
      logic [WORD_W-1:0] xa, ya, rr;
      logic [64:0]       o;
      always_comb begin
        elw  = 8'd16 << wsel;
        lo   = 8'(j) * elw;
        up   = 8'd64 - elw;
        live = (j < (4 >> wsel));
        xa   = (a >> lo) << up;
        ya   = (b >> lo) << up;
        o    = aligned_op(op, xa, ya);
        rr   = (o[63:0] >> up) << lo;
      end
      assign part[j] = live ? rr : '0;
      assign flg[j]  = live & o[64];
    end
  endgenerate

  always_comb begin
    res = '0;
    for (int k = 0; k < SLOTS; k++) res = res | part[k];
  end
endmodule

// File: rtl/vxu_seq.sv
module vxu_seq
  import vxu_pkg::*;
#(
  parameter  int NWORD = 32,
  localparam int MAXEL = NWORD * SLOTS,
  localparam int WW    = $clog2(NWORD),
  localparam int LW    = $clog2(MAXEL) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    cfg_width,
  input  logic [LW-1:0] cfg_len,
  output logic          busy,
  output logic          done,
  output logic [WW-1:0] word_idx,
  output logic [1:0]    wsel,
  output logic [LW-1:0] len
);
  logic          busy_q, busy_d, done_q, done_d;
  logic [WW-1:0] idx_q, idx_d;
  logic [LW-1:0] nw_q, nw_d, len_q, len_d;
  logic [1:0]    ws_q, ws_d;

  logic [1:0]    wn, sh;
  logic [LW-1:0] cap, eff, nw;

  always_comb begin
    wn  = norm_width(cfg_width);
    sh  = 2'd2 - wn;
    cap = LW'(MAXEL) >> wn;
    eff = (cfg_len > cap) ? cap : cfg_len;
    nw  = (eff + ((LW'(1) << sh) - LW'(1))) >> sh;
  end

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    idx_d  = idx_q;
    nw_d   = nw_q;
    len_d  = len_q;
    ws_d   = ws_q;
    if (busy_q) begin
      idx_d = idx_q + WW'(1);
      if (LW'(idx_q) == nw_q - LW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        idx_d  = '0;
      end
    end else if (start) begin
      ws_d  = wn;
      len_d = eff;
      nw_d  = nw;
      idx_d = '0;
      if (nw == '0) done_d = 1'b1;
      else          busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      nw_q   <= '0;
      len_q  <= '0;
      ws_q   <= 2'd2;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
      nw_q   <= nw_d;
      len_q  <= len_d;
      ws_q   <= ws_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign word_idx = idx_q;
  assign wsel     = ws_q;
  assign len      = len_q;

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) || $past(start)));
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(wsel) && $stable(len)));
endmodule

// File: rtl/vxu_top.sv
module vxu_top
  import vxu_pkg::*;
#(
  parameter  int NVREG = 32,
  parameter  int NWORD = 32,
  parameter  int NFREG = 32,
  localparam int MAXEL = NWORD * SLOTS,
  localparam int RW    = $clog2(NVREG),
  localparam int WW    = $clog2(NWORD),
  localparam int FW    = $clog2(NFREG),
  localparam int EW    = $clog2(MAXEL),
  localparam int LW    = EW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [1:0]        cmd_form,
  input  logic [RW-1:0]     cmd_vd,
  input  logic [RW-1:0]     cmd_vs1,
  input  logic [RW-1:0]     cmd_vs2,
  input  logic              cmd_masked,
  input  logic [FW-1:0]     cmd_mreg,
  input  logic [FW-1:0]     cmd_freg,
  input  logic [WORD_W-1:0] cmd_scalar,
  input  logic [1:0]        cfg_width,
  input  logic [LW-1:0]     cfg_len,
  output logic              busy,
  output logic              done,
  input  logic              ld_we,
  input  logic [RW-1:0]     ld_reg,
  input  logic [WW-1:0]     ld_word,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              fl_we,
  input  logic [FW-1:0]     fl_reg,
  input  logic [MAXEL-1:0]  fl_data,
  input  logic [RW-1:0]     rd_reg,
  input  logic [WW-1:0]     rd_word,
  output logic [WORD_W-1:0] rd_data,
  input  logic [FW-1:0]     fr_reg,
  output logic [MAXEL-1:0]  fr_data
);
  logic [WORD_W-1:0] vreg [NVREG][NWORD];
  logic [MAXEL-1:0]  freg [NFREG];

  logic              start;
  logic [WW-1:0]     idx;
  logic [1:0]        wsel;
  logic [LW-1:0]     len;

  // command latched at acceptance
  logic [2:0]        op_q;
  logic [1:0]        form_q;
  logic [RW-1:0]     vd_q, vs1_q, vs2_q;
  logic              msk_q;
  logic [FW-1:0]     mreg_q, freg_q;
  logic [WORD_W-1:0] scal_q;

  assign start = cmd_valid & ~busy;

  vxu_seq #(.NWORD(NWORD)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cfg_width(cfg_width),
    .cfg_len  (cfg_len),
    .busy     (busy),
    .done     (done),
    .word_idx (idx),
    .wsel     (wsel),
    .len      (len)
  );

  always_ff @(posedge clk) begin
    if (start) begin
      op_q   <= cmd_op;
      form_q <= cmd_form;
      vd_q   <= cmd_vd;
      vs1_q  <= cmd_vs1;
      vs2_q  <= cmd_vs2;
      msk_q  <= cmd_masked;
      mreg_q <= cmd_mreg;
      freg_q <= cmd_freg;
      scal_q <= cmd_scalar;
    end
  end

  // operand selection
  logic [WORD_W-1:0] bc, opa, opb, old, res, nxt, wmask, fld;
  logic [MAXEL-1:0]  mask_vec;
  logic [SLOTS-1:0]  flg, en;
  logic [LW:0]       ebig [SLOTS];
  int                elw;

  always_comb begin
    bc       = splat(scal_q, wsel);
    opa      = (vform_e'(form_q) == FM_SV) ? bc : vreg[vs1_q][idx];
    opb      = (vform_e'(form_q) == FM_VS) ? bc : vreg[vs2_q][idx];
    old      = vreg[vd_q][idx];
    mask_vec = freg[mreg_q];
  end

  vxu_word_alu u_alu (
    .op  (op_q),
    .wsel(wsel),
    .a   (opa),
    .b   (opb),
    .res (res),
    .flg (flg)
  );

  // per-element write enables: inside length, inside word, mask bit set
  always_comb begin
    elw   = 16 << wsel;
    fld   = (wsel == 2'd2) ? '1 : ((64'd1 << elw) - 64'd1);
    wmask = '0;
    for (int j = 0; j < SLOTS; j++) begin
      ebig[j] = ((LW+1)'(idx) << (2'd2 - wsel)) + (LW+1)'(j);
      en[j]   = busy && (j < (4 >> wsel)) && (ebig[j] < {1'b0, len})
                && (!msk_q || mask_vec[ebig[j][EW-1:0]]);
      if (en[j]) wmask = wmask | (fld << (j * elw));
    end
    nxt = (res & wmask) | (old & ~wmask);
  end

  // register files: execution writes while busy, loads only while idle
  always_ff @(posedge clk) begin
    if (busy) begin
      vreg[vd_q][idx] <= nxt;
      for (int j = 0; j < SLOTS; j++)
        if (en[j]) freg[freg_q][ebig[j][EW-1:0]] <= flg[j];
    end else begin
      if (ld_we) vreg[ld_reg][ld_word] <= ld_data;
      if (fl_we) freg[fl_reg]          <= fl_data;
    end
  end

  assign rd_data = vreg[rd_reg][rd_word];
  assign fr_data = freg[fr_reg];

  // R3
  word_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (((LW+1)'(idx) << (2'd2 - wsel)) < {1'b0, len}));
  // R5
  sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == 3'd5 && wsel == 2'd2 && flg[0]) |->
      (res == 64'h7FFF_FFFF_FFFF_FFFF || res == 64'h8000_0000_0000_0000));
endmodule

// File: tb/tb_vxu_top.sv
module tb_vxu_top;
  localparam int NVREG = 32, NWORD = 32, NFREG = 32, MAXEL = 128;
  localparam int RW = 5, WW = 5, FW = 5, LW = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_valid;
  logic [2:0]        cmd_op;
  logic [1:0]        cmd_form;
  logic [RW-1:0]     cmd_vd, cmd_vs1, cmd_vs2;
  logic              cmd_masked;
  logic [FW-1:0]     cmd_mreg, cmd_freg;
  logic [63:0]       cmd_scalar;
  logic [1:0]        cfg_width;
  logic [LW-1:0]     cfg_len;
  logic              busy, done;
  logic              ld_we;
  logic [RW-1:0]     ld_reg;
  logic [WW-1:0]     ld_word;
  logic [63:0]       ld_data;
  logic              fl_we;
  logic [FW-1:0]     fl_reg;
  logic [MAXEL-1:0]  fl_data;
  logic [RW-1:0]     rd_reg;
  logic [WW-1:0]     rd_word;
  logic [63:0]       rd_data;
  logic [FW-1:0]     fr_reg;
  logic [MAXEL-1:0]  fr_data;

  vxu_top dut (.*);

  always #2 clk = ~clk;

  int          checks = 0;
  int          fails  = 0;
  int          cyc    = 0;
  bit          reported = 0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;
  logic [63:0] mv [NVREG][NWORD];
  logic [MAXEL-1:0] mf [NFREG];

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      report();
      $finish;
    end
  end

  function automatic logic [63:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  task automatic note(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic signed [66:0] sx(logic [63:0] x, int w);
    logic [66:0] t;
    t = {3'b000, x} << (67 - w);
    return $signed(t) >>> (67 - w);
  endfunction

  // element-by-element reference following the requirements
  task automatic model(int op, int form, int vd, int vs1, int vs2, bit msk, int mreg,
                       int freg, logic [63:0] scal, int wi, int len);
    int wn, w, epw, cap, eff, wd, sl;
    logic [63:0] mw, av, bv, r;
    logic signed [66:0] t, mx, mn;
    bit f;
    wn  = (wi == 3) ? 2 : wi;
    w   = 16 << wn;
    epw = 4 >> wn;
    cap = 128 >> wn;
    eff = (len > cap) ? cap : len;
    mw  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    mx  = (67'sd1 <<< (w - 1)) - 67'sd1;
    mn  = -(67'sd1 <<< (w - 1));
    for (int e = 0; e < eff; e++) begin
      wd = e / epw;
      sl = e % epw;
      if (msk && !mf[mreg][e]) continue;
      av = (form == 2) ? (scal & mw) : ((mv[vs1][wd] >> (sl * w)) & mw);
      bv = (form == 1) ? (scal & mw) : ((mv[vs2][wd] >> (sl * w)) & mw);
      f  = 0;
      case (op)
        0: begin t = sx(av, w) + sx(bv, w); r = t[63:0] & mw; f = (t > mx) || (t < mn); end
        1: begin t = sx(av, w) - sx(bv, w); r = t[63:0] & mw; f = (t > mx) || (t < mn); end
        2: r = av & bv;
        3: r = av | bv;
        4: r = av ^ bv;
        default: begin
          t = sx(av, w) + sx(bv, w);
          if (t > mx)      begin r = mx[63:0] & mw; f = 1; end
          else if (t < mn) begin r = mn[63:0] & mw; f = 1; end
          else                   r = t[63:0] & mw;
        end
      endcase
      mv[vd][wd] = (mv[vd][wd] & ~(mw << (sl * w))) | (r << (sl * w));
      mf[freg][e] = f;
    end
  endtask

  task automatic check_reg(int r, string req);
    int bad = -1;
    logic [63:0] act = '0;
    for (int w = 0; w < NWORD; w++) begin
      rd_reg  = RW'(r);
      rd_word = WW'(w);
      #1;
      if (rd_data !== mv[r][w] && bad < 0) begin bad = w; act = rd_data; end
    end
    if (bad < 0) note(1, req, "vector data", 0, 0);
    else note(0, req, $sformatf("vreg %0d word %0d", r, bad), act, mv[r][bad]);
  endtask

  task automatic check_flag(int r, string req);
    fr_reg = FW'(r);
    #1;
    note(fr_data === mf[r], req, $sformatf("flag reg %0d", r), fr_data, mf[r]);
  endtask

  task automatic run(int op, int form, int vd, int vs1, int vs2, bit msk, int mreg,
                     int freg, int wi, int len, bit inj, string dreq, string freq);
    int wn, epw, cap, eff, nw, c;
    logic [63:0] scal;
    scal = rnd();
    wn  = (wi == 3) ? 2 : wi;
    epw = 4 >> wn;
    cap = 128 >> wn;
    eff = (len > cap) ? cap : len;
    nw  = (eff + epw - 1) / epw;
    @(negedge clk);
    cmd_op = 3'(op); cmd_form = 2'(form); cmd_vd = RW'(vd); cmd_vs1 = RW'(vs1);
    cmd_vs2 = RW'(vs2); cmd_masked = msk; cmd_mreg = FW'(mreg); cmd_freg = FW'(freg);
    cmd_scalar = scal; cfg_width = 2'(wi); cfg_len = LW'(len);
    cmd_valid = 1;
    @(posedge clk); #1;
    cmd_valid = 0;
    c = 0;
    if (inj) begin
      // R9: command and loads offered while busy
      cmd_valid = 1; cmd_vd = 5'd9; cfg_len = 8'd3;
      ld_we = 1; ld_reg = 5'd9; ld_word = 5'd0; ld_data = ~mv[9][0];
      fl_we = 1; fl_reg = 5'd9; fl_data = ~mf[9];
      @(posedge clk); #1;
      cmd_valid = 0; ld_we = 0; fl_we = 0;
      c = 1;
    end
    while (!done && c < 300) begin
      @(posedge clk); #1;
      c++;
    end
    note(c == nw, "R8", "edges from accept to done", 128'(c), 128'(nw));
    @(posedge clk); #1;
    note(!done && !busy, inj ? "R9" : "R8", "idle after done pulse",
         {busy, done}, 2'b00);
    model(op, form, vd, vs1, vs2, msk, mreg, freg, scal, wi, len);
    check_reg(vd, dreq);
    check_flag(freg, freq);
    if (inj) begin
      check_reg(9, "R9");
      check_flag(9, "R9");
    end
  endtask

  initial begin
    string dreq, freq;
    int len, cap;
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_form = 0; cmd_vd = 0; cmd_vs1 = 0;
    cmd_vs2 = 0; cmd_masked = 0; cmd_mreg = 0; cmd_freg = 0; cmd_scalar = 0;
    cfg_width = 0; cfg_len = 0; ld_we = 0; ld_reg = 0; ld_word = 0; ld_data = 0;
    fl_we = 0; fl_reg = 0; fl_data = 0; rd_reg = 0; rd_word = 0; fr_reg = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: during reset
    note(!busy && !done, "R1", "busy/done in reset", {busy, done}, 2'b00);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    note(!busy && !done, "R1", "busy/done after reset", {busy, done}, 2'b00);

    // fill both files through the load ports
    for (int r = 0; r < NVREG; r++)
      for (int w = 0; w < NWORD; w++) begin
        @(negedge clk);
        mv[r][w] = rnd();
        ld_we = 1; ld_reg = RW'(r); ld_word = WW'(w); ld_data = mv[r][w];
      end
    for (int r = 0; r < NFREG; r++) begin
      @(negedge clk);
      ld_we = 0;
      mf[r] = {rnd(), rnd()};
      fl_we = 1; fl_reg = FW'(r); fl_data = mf[r];
    end
    @(negedge clk);
    fl_we = 0;

    // sweep: width x opcode x operand form x masking (R2, R4..R7, R10)
    for (int wi = 0; wi < 4; wi++)
      for (int op = 0; op < 6; op++)
        for (int form = 0; form < 3; form++)
          for (int mk = 0; mk < 2; mk++) begin
            cap = 128 >> ((wi == 3) ? 2 : wi);
            len = (op * 53 + form * 29 + mk * 17 + wi * 41 + 9) % 160;
            if (wi == 3)           dreq = "R2";
            else if (len > cap)    dreq = "R3";
            else if (mk != 0)      dreq = "R6";
            else if (form != 0)    dreq = "R7";
            else if (op == 5)      dreq = "R5";
            else                   dreq = "R4";
            freq = (op == 5) ? "R5" : "R10";
            run(op, form, 10 + op, 1, 2, mk[0], 5, 20 + form, wi, len, 0, dreq, freq);
          end

    // R3: maximum request clamps to 32 elements at 64 bits
    run(0, 0, 16, 1, 2, 0, 5, 24, 2, 255, 0, "R3", "R10");
    // R8: zero length finishes at once and writes nothing
    run(1, 0, 17, 1, 2, 0, 5, 25, 0, 0, 0, "R8", "R8");
    // R9: command and loads offered while busy are dropped
    run(5, 1, 18, 1, 2, 0, 5, 26, 0, 100, 1, "R5", "R5");
    // R6: in-place masked saturating add, mask register is the status register
    run(5, 0, 1, 1, 2, 1, 7, 7, 0, 128, 0, "R6", "R6");
    // R7: scalar-first subtract at 32 bits, in place on the second source
    run(1, 2, 2, 1, 2, 0, 5, 27, 1, 64, 0, "R7", "R10");

    report();
    $finish;
  end
endmodule